// File: doc/BRIEF.md
# Streaming NAND Hamming ECC Generator

This block sits on the data path of a NAND flash controller. It computes a Hamming-style error-correcting code over the bytes that pass through during a page transfer. The page is split into chunks of 256 bytes. For each chunk the block builds two 11-bit parity words. The first word covers the positions whose index bits are one. The second word, the complement word, covers the positions whose index bits are zero. A 512-byte page uses two chunk pairs: the low pair covers the first half and the high pair covers the second half.

Software or a page sequencer pulses a clear request before each page and waits for the busy flag to drop. After that it streams data beats. A beat is either one byte or a 16-bit word that carries two bytes. When the last byte of the page has been absorbed, a done flag rises. The four parity words can then be read directly. When a 22-bit code is formed as {complement word, first word}, the stored code and the recomputed code differ in exactly 11 bits when a single data bit has flipped. In that case the low 11 bits of the difference give the byte index times 8 plus the bit index of the flipped bit.

Top module: `nand_ecc_gen`

## Requirements
- R1: After rstN is low, all four parity outputs, clrBusy and pageDone are zero.
- R2: A clrReq high for one cycle makes clrBusy read 1 after the next clock edge. One edge later clrBusy reads 0, and the parity outputs and pageDone are zero.
- R3: Within a chunk, bit k (k = 0..2) of the first word is the XOR of every data bit whose bit number within its byte has bit k set. Bit 3+j (j = 0..7) is the XOR of every data bit whose byte offset in the chunk has bit j set. The complement word holds the same sums taken over the positions where that index bit is zero.
- R4: With pageMode512 = 1, eccOddLo/eccEvenLo cover page bytes 0..255 and eccOddHi/eccEvenHi cover bytes 256..511.
- R5: With pageMode512 = 0, the page is 256 bytes, only the low pair accumulates, and eccOddHi/eccEvenHi stay zero.
- R6: With wideBeat = 1, a beat carries two bytes: beatData[7:0] is the earlier byte and beatData[15:8] is the next one. With wideBeat = 0, only beatData[7:0] is used and one byte is counted.
- R7: pageDone rises after the final byte of the page (byte 255 or byte 511) and stays high until the next clear. Beats arriving after the final byte change no output.
- R8: A beat presented while clrBusy is 1 is ignored.
- R9: If one data bit at byte b, bit k of a chunk is inverted, the 22-bit code {complement, first} changes in exactly 11 bits, and the first word changes by 8*b+k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pageMode512 | input | 1 | 1: 512-byte page, 0: 256-byte page |
| wideBeat | input | 1 | 1: beat carries two bytes, 0: one byte |
| beatValid | input | 1 | Beat present this cycle |
| beatData | input | 16 | Beat data, earlier byte in [7:0] |
| clrReq | input | 1 | Clear request pulse before a page |
| clrBusy | output | 1 | Clear in progress; drops to acknowledge |
| pageDone | output | 1 | Final byte of the page absorbed |
| eccOddLo | output | 11 | First word, low chunk |
| eccEvenLo | output | 11 | Complement word, low chunk |
| eccOddHi | output | 11 | First word, high chunk |
| eccEvenHi | output | 11 | Complement word, high chunk |

## Verification
The bench compares the outputs against parity sums recomputed from the byte array after several kinds of page stream. It uses pseudo-random pages in byte beats and in word beats, in both page sizes, which separates errors in lane order, in chunk selection and in the high-pair gating. It then sweeps a single inverted bit over every byte offset of a chunk, on top of a fixed random background. This pins down each line-parity bit and checks the 11-bit distance. Extra beats after the end of the page, and a beat placed in the busy cycle, show whether the block leaks bytes outside the page window.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;
  localparam int unsigned BYTE_W      = 8;
  localparam int unsigned COL_W       = 3;
  localparam int unsigned CHUNK_BYTES = 256;
  localparam int unsigned IDX_W       = $clog2(CHUNK_BYTES);
  localparam int unsigned PAR_W       = COL_W + IDX_W;
  localparam int unsigned CHUNKS      = 2;
  localparam int unsigned LANES       = 2;
  localparam int unsigned BEAT_W      = LANES * BYTE_W;
  localparam int unsigned CNT_W       = $clog2(CHUNK_BYTES * CHUNKS) + 1;
  localparam int unsigned SEL_W       = CNT_W - IDX_W;

  // control-to-datapath strobes
  typedef struct packed {
    logic                            clrAcc;
    logic [LANES-1:0]                laneEn;
    logic [LANES-1:0][CNT_W-1:0]     laneIdx;
  } eccStrobe_t;

  // one chunk's parity pair
  typedef struct packed {
    logic [PAR_W-1:0] evenPar;
    logic [PAR_W-1:0] oddPar;
  } eccPair_t;

  // parity contribution of one byte at a given offset inside its chunk
  function automatic eccPair_t byteContrib(input logic [BYTE_W-1:0] b,
                                           input logic [IDX_W-1:0] off);
    eccPair_t r;
    logic     p;
    r = '0;
    p = ^b;
    for (int k = 0; k < int'(COL_W); k++) begin
      for (int n = 0; n < int'(BYTE_W); n++) begin
        if (((n >> k) & 1) == 1) r.oddPar[k]  = r.oddPar[k]  ^ b[n];
        else                     r.evenPar[k] = r.evenPar[k] ^ b[n];
      end
    end
    for (int j = 0; j < int'(IDX_W); j++) begin
      r.oddPar[COL_W+j]  = p &  off[j];
      r.evenPar[COL_W+j] = p & ~off[j];
    end
    return r;
  endfunction
endpackage

// File: rtl/nand_ecc_ctrl.sv
module nand_ecc_ctrl
  import nand_ecc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       clrReq,
  input  logic       pageMode512,
  input  logic       wideBeat,
  input  logic       beatValid,
  output eccStrobe_t strobe,
  output logic       clrBusy,
  output logic       pageDone
);
  logic [CNT_W-1:0]            byteCnt;
  logic [CNT_W-1:0]            nextCnt;
  logic [CNT_W-1:0]            limit;
  logic                        accept;
  logic [LANES-1:0]            laneEnV;
  logic [LANES-1:0][CNT_W-1:0] laneIdxV;

  assign limit  = pageMode512 ? CNT_W'(CHUNK_BYTES * CHUNKS) : CNT_W'(CHUNK_BYTES);
  assign accept = beatValid && !clrBusy;

  for (genvar l = 0; l < int'(LANES); l++) begin : gLane
    logic laneReq;
    if (l == 0) begin : gFirst
      assign laneReq = accept;
    end else begin : gUpper
      assign laneReq = accept && wideBeat;
    end
    assign laneIdxV[l] = byteCnt + CNT_W'(l);
    assign laneEnV[l]  = laneReq && (laneIdxV[l] < limit);
  end

  always_comb begin
    nextCnt = byteCnt;
    for (int l = 0; l < int'(LANES); l++) begin
      if (laneEnV[l]) nextCnt = nextCnt + CNT_W'(1);
    end
  end

  always_comb begin
    strobe.clrAcc  = clrBusy;
    strobe.laneEn  = laneEnV;
    strobe.laneIdx = laneIdxV;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      byteCnt  <= '0;
      clrBusy  <= 1'b0;
      pageDone <= 1'b0;
    end else if (clrBusy) begin
      byteCnt  <= '0;
      pageDone <= 1'b0;
      clrBusy  <= clrReq;
    end else begin
      clrBusy <= clrReq;
      byteCnt <= nextCnt;
      if ((|laneEnV) && (nextCnt == limit)) pageDone <= 1'b1;
    end
  end

  // R2
  clr_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    clrReq |=> clrBusy);

  // R2
  clr_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clrBusy && !clrReq) |=> (!clrBusy && !pageDone));

  // R7
  done_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pageDone && !clrBusy) |=> pageDone);

  // R8
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    clrBusy |-> (strobe.laneEn == '0));
endmodule

// File: rtl/nand_ecc_datapath.sv
module nand_ecc_datapath
  import nand_ecc_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  eccStrobe_t              strobe,
  input  logic [BEAT_W-1:0]       beatData,
  output eccPair_t [CHUNKS-1:0]   accOut
);
  eccPair_t [CHUNKS-1:0] accReg;
  eccPair_t [CHUNKS-1:0] delta;

  always_comb begin
    delta = '0;
    for (int c = 0; c < int'(CHUNKS); c++) begin
      for (int l = 0; l < int'(LANES); l++) begin
        if (strobe.laneEn[l] &&
            (strobe.laneIdx[l][CNT_W-1:IDX_W] == SEL_W'(c))) begin
          delta[c] = delta[c] ^ byteContrib(beatData[l*BYTE_W +: BYTE_W],
                                            strobe.laneIdx[l][IDX_W-1:0]);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)             accReg <= '0;
    else if (strobe.clrAcc) accReg <= '0;
    else                   accReg <= accReg ^ delta;
  end

  assign accOut = accReg;

  // R2
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrAcc |=> (accReg == '0));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.clrAcc && (strobe.laneEn == '0)) |=> $stable(accReg));
endmodule

// File: rtl/nand_ecc_gen.sv
module nand_ecc_gen
  import nand_ecc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 pageMode512,
  input  logic                 wideBeat,
  input  logic                 beatValid,
  input  logic [BEAT_W-1:0]    beatData,
  input  logic                 clrReq,
  output logic                 clrBusy,
  output logic                 pageDone,
  output logic [PAR_W-1:0]     eccOddLo,
  output logic [PAR_W-1:0]     eccEvenLo,
  output logic [PAR_W-1:0]     eccOddHi,
  output logic [PAR_W-1:0]     eccEvenHi
);
  eccStrobe_t            strobe;
  eccPair_t [CHUNKS-1:0] acc;

  nand_ecc_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .clrReq     (clrReq),
    .pageMode512(pageMode512),
    .wideBeat   (wideBeat),
    .beatValid  (beatValid),
    .strobe     (strobe),
    .clrBusy    (clrBusy),
    .pageDone   (pageDone)
  );

  nand_ecc_datapath dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .beatData(beatData),
    .accOut  (acc)
  );

  assign eccOddLo  = acc[0].oddPar;
  assign eccEvenLo = acc[0].evenPar;
  assign eccOddHi  = acc[1].oddPar;
  assign eccEvenHi = acc[1].evenPar;

  // R5
  hi_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!pageMode512 && !clrBusy && (acc[1] == '0)) |=> (acc[1] == '0));
endmodule

// File: tb/nand_ecc_gen_tb_top.sv
module nand_ecc_gen_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pageMode512 = 1'b0;
  logic        wideBeat = 1'b0;
  logic        beatValid = 1'b0;
  logic [15:0] beatData = '0;
  logic        clrReq = 1'b0;
  logic        clrBusy, pageDone;
  logic [10:0] eccOddLo, eccEvenLo, eccOddHi, eccEvenHi;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  logic [7:0] mem [512];

  always #4 clk = ~clk;

  nand_ecc_gen dut_i (
    .clk(clk), .rstN(rstN), .pageMode512(pageMode512), .wideBeat(wideBeat),
    .beatValid(beatValid), .beatData(beatData), .clrReq(clrReq),
    .clrBusy(clrBusy), .pageDone(pageDone), .eccOddLo(eccOddLo),
    .eccEvenLo(eccEvenLo), .eccOddHi(eccOddHi), .eccEvenHi(eccEvenHi)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [21:0] refPair(input int base);
    logic [10:0] o, e;
    o = '0; e = '0;
    for (int off = 0; off < 256; off++) begin
      for (int n = 0; n < 8; n++) begin
        if (mem[base+off][n]) begin
          for (int k = 0; k < 3; k++) begin
            if (((n >> k) & 1) == 1) o[k] = ~o[k]; else e[k] = ~e[k];
          end
          for (int j = 0; j < 8; j++) begin
            if (((off >> j) & 1) == 1) o[3+j] = ~o[3+j]; else e[3+j] = ~e[3+j];
          end
        end
      end
    end
    return {e, o};
  endfunction

  task automatic fillRandom(input logic [31:0] seed);
    logic [31:0] s;
    s = seed;
    for (int i = 0; i < 512; i++) begin
      s = s * 32'd1103515245 + 32'd12345;
      mem[i] = s[23:16];
    end
  endtask

  task automatic doClear(input bit chk);
    @(negedge clk) clrReq = 1'b1;
    @(negedge clk) clrReq = 1'b0;
    if (chk) check(clrBusy == 1'b1, "R2", "busy after request", 32'(clrBusy), 32'd1);
    @(negedge clk);
    if (chk) begin
      check(clrBusy == 1'b0, "R2", "busy dropped", 32'(clrBusy), 32'd0);
      check({eccEvenHi, eccOddHi, eccEvenLo, eccOddLo} == '0, "R2", "parity cleared",
            32'({eccEvenHi, eccOddHi, eccEvenLo, eccOddLo}), 32'd0);
      check(pageDone == 1'b0, "R2", "done cleared", 32'(pageDone), 32'd0);
    end
  endtask

  task automatic streamBytes(input bit wide, input int first, input int count);
    for (int i = first; i < first + count; i += (wide ? 2 : 1)) begin
      @(negedge clk);
      beatValid = 1'b1;
      wideBeat  = wide;
      beatData  = wide ? {mem[i+1], mem[i]} : {8'hA5, mem[i]};
    end
    @(negedge clk) beatValid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL R7 watchdog actual=%0h expected=%0h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [21:0] expLo, expHi, baseCode, got, diff;
    repeat (3) @(negedge clk);
    // R1 reset state
    check({eccEvenHi, eccOddHi, eccEvenLo, eccOddLo} == '0, "R1", "parity at reset",
          32'({eccEvenHi, eccOddHi, eccEvenLo, eccOddLo}), 32'd0);
    check(clrBusy == 1'b0 && pageDone == 1'b0, "R1", "flags at reset",
          32'({clrBusy, pageDone}), 32'd0);
    @(negedge clk) rstN = 1'b1;

    // R3 R4 512-byte page, byte beats, done only at the end
    pageMode512 = 1'b1;
    doClear(1);
    fillRandom(32'h1234_5678);
    streamBytes(0, 0, 256);
    check(pageDone == 1'b0, "R7", "no done at half page", 32'(pageDone), 32'd0);
    streamBytes(0, 256, 256);
    expLo = refPair(0); expHi = refPair(256);
    check({eccEvenLo, eccOddLo} == expLo, "R4", "low pair bytes", 32'({eccEvenLo, eccOddLo}), 32'(expLo));
    check({eccEvenHi, eccOddHi} == expHi, "R4", "high pair bytes", 32'({eccEvenHi, eccOddHi}), 32'(expHi));
    check(pageDone == 1'b1, "R7", "done after byte 511", 32'(pageDone), 32'd1);

    // R6 512-byte page, word beats
    doClear(1);
    fillRandom(32'h0BAD_F00D);
    streamBytes(1, 0, 512);
    expLo = refPair(0); expHi = refPair(256);
    check({eccEvenLo, eccOddLo} == expLo, "R6", "low pair words", 32'({eccEvenLo, eccOddLo}), 32'(expLo));
    check({eccEvenHi, eccOddHi} == expHi, "R6", "high pair words", 32'({eccEvenHi, eccOddHi}), 32'(expHi));

    // R5 256-byte page
    pageMode512 = 1'b0;
    doClear(1);
    fillRandom(32'h5555_AAAA);
    streamBytes(0, 0, 256);
    expLo = refPair(0);
    check({eccEvenLo, eccOddLo} == expLo, "R5", "small page low pair", 32'({eccEvenLo, eccOddLo}), 32'(expLo));
    check({eccEvenHi, eccOddHi} == '0, "R5", "small page high pair", 32'({eccEvenHi, eccOddHi}), 32'd0);
    check(pageDone == 1'b1, "R5", "done after byte 255", 32'(pageDone), 32'd1);

    // R7 beats after the page end are ignored
    for (int i = 256; i < 264; i++) mem[i] = 8'hFF;
    streamBytes(1, 256, 8);
    check({eccEvenHi, eccOddHi, eccEvenLo, eccOddLo} == {22'd0, expLo}, "R7", "overrun ignored",
          32'({eccEvenLo, eccOddLo}), 32'(expLo));
    check(pageDone == 1'b1, "R7", "done holds", 32'(pageDone), 32'd1);

    // R8 beat during busy ignored
    @(negedge clk) clrReq = 1'b1;
    @(negedge clk) clrReq = 1'b0;
    beatValid = 1'b1; wideBeat = 1'b1; beatData = 16'hFFFF;
    @(negedge clk) beatValid = 1'b0;
    fillRandom(32'h0F0F_3C3C);
    streamBytes(0, 0, 256);
    expLo = refPair(0);
    check({eccEvenLo, eccOddLo} == expLo, "R8", "busy beat dropped", 32'({eccEvenLo, eccOddLo}), 32'(expLo));

    // R9 R3 single-bit sweep over every byte offset
    fillRandom(32'hCAFE_0001);
    baseCode = refPair(0);
    for (int off = 0; off < 256; off++) begin
      int bitPos;
      bitPos = (off * 3) % 8;
      mem[off][bitPos] = ~mem[off][bitPos];
      doClear(0);
      streamBytes(1, 0, 256);
      got = {eccEvenLo, eccOddLo};
      expLo = refPair(0);
      check(got == expLo, "R3", "flipped page code", 32'(got), 32'(expLo));
      diff = got ^ baseCode;
      check($countones(diff) == 11 && diff[10:0] == 11'(off * 8 + bitPos), "R9",
            "single-bit syndrome", 32'(diff), 32'(off * 8 + bitPos));
      mem[off][bitPos] = ~mem[off][bitPos];
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule